// File: doc/BRIEF.md
# Exclusive Access Monitor

This block watches every address transaction that a memory completer accepts on an AXI4 port and decides the outcome of exclusive (lock bit set) accesses. Each accepted transaction presents its ID, its start address, whether it is a read or a write, and its one-bit lock flag. The lock flag is 0 for a normal access and 1 for an exclusive one. The monitor holds one reservation slot for each possible transaction ID. A slot is a valid bit plus the address that the ID last read exclusively.

One cycle after a transaction is presented, the block returns a two-bit response code (00 normal OK, 01 exclusive OK). It also returns a write-permit flag that tells the memory array whether this write may change storage.

An exclusive write succeeds only when its own ID's slot is valid and holds the same address. A successful exclusive write, or any normal write, then invalidates every slot that holds that address, whatever the ID. As a result, a competing exclusive write to the same location fails.

Top module: `excl_monitor`

## Requirements
- R1: After reset every slot is invalid, so an exclusive write from any ID gets response 00 with write permit 0, and resp_valid is 0 until a transaction is presented.
- R2: An exclusive read (txn_write=0, txn_excl=1) stores its address in its ID's slot and is answered with code 01 and write_permit 0.
- R3: An exclusive write whose ID slot is valid and holds the same address is answered with code 01 and write_permit 1.
- R4: After a successful exclusive write, every slot that held the written address is invalid, whatever its ID. A later exclusive write from any of those IDs to that address gets 00 and write_permit 0.
- R5: An exclusive write with no matching slot (slot invalid, or a different address) is answered with code 00 and write_permit 0, and it leaves every slot unchanged.
- R6: Each ID holds exactly one address. A new exclusive read on an ID replaces the previously stored address, so an exclusive write to the old address fails and one to the new address succeeds.
- R7: Reservations by different IDs on different addresses are independent, and each can complete with code 01.
- R8: A normal write (txn_write=1, txn_excl=0) is answered with code 00 and write_permit 1, and it invalidates every slot holding its address.
- R9: A normal read is answered with code 00 and write_permit 0, and it leaves every slot unchanged.
- R10: resp_valid is 1 in exactly the cycle after a cycle with txn_valid=1, and 0 otherwise. The slot count equals 2^ID_WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | An accepted address transaction is presented this cycle |
| txn_id | input | ID_WIDTH | Transaction ID |
| txn_addr | input | ADDR_WIDTH | Start address of the transaction |
| txn_write | input | 1 | 1 for write, 0 for read |
| txn_excl | input | 1 | Lock flag: 1 exclusive, 0 normal |
| resp_valid | output | 1 | Response for the previous cycle's transaction is present |
| resp_code | output | 2 | 00 normal OK, 01 exclusive OK |
| write_permit | output | 1 | The memory may update storage for this write |

## Verification
The bench goes after the case where a winning exclusive write must invalidate other IDs' slots on the same address. A design that cleared only its own slot would let a second ID win the same location as well.

It also checks that a failed exclusive write leaves the table untouched. A design that cleared on failure would wrongly turn the true owner's later write into a failure.

Reservation replacement is exercised as well: a design that kept the stale address would let an exclusive write to the old location succeed.

A seeded sweep over all four IDs and a handful of colliding addresses compares every response with a table model kept in the bench. This catches wrong codes, permits and clearing under mixed traffic.

// File: rtl/excl_pkg.sv
package excl_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } resp_e;

  typedef enum logic [1:0] {
    OP_RD_NORM = 2'd0,
    OP_RD_EXCL = 2'd1,
    OP_WR_NORM = 2'd2,
    OP_WR_EXCL = 2'd3
  } op_e;

  // Decode direction and lock flag into one operation class.
  function automatic op_e classify(input logic is_write, input logic is_excl);
    op_e op;
    case ({is_write, is_excl})
      2'b00:   op = OP_RD_NORM;
      2'b01:   op = OP_RD_EXCL;
      2'b10:   op = OP_WR_NORM;
      default: op = OP_WR_EXCL;
    endcase
    return op;
  endfunction

  // Response code chosen from the operation and the requester's own slot match.
  function automatic resp_e resp_for(input op_e op, input logic own_hit);
    resp_e r;
    case (op)
      OP_RD_EXCL: r = RESP_EXOKAY;
      OP_WR_EXCL: r = own_hit ? RESP_EXOKAY : RESP_OKAY;
      default:    r = RESP_OKAY;
    endcase
    return r;
  endfunction

  // Whether storage may change for this operation.
  function automatic logic permit_for(input op_e op, input logic own_hit);
    logic p;
    case (op)
      OP_WR_NORM: p = 1'b1;
      OP_WR_EXCL: p = own_hit;
      default:    p = 1'b0;
    endcase
    return p;
  endfunction

  // A write that reaches storage releases every slot on its address.
  function automatic logic releases(input op_e op, input logic own_hit);
    return permit_for(op, own_hit);
  endfunction

endpackage

// File: rtl/excl_table.sv
module excl_table #(
  parameter int ID_WIDTH   = 2,
  parameter int ADDR_WIDTH = 16,
  localparam int DEPTH     = 1 << ID_WIDTH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            set_vec,
  input  logic [ADDR_WIDTH-1:0]       set_addr,
  input  logic [DEPTH-1:0]            clr_vec,
  output logic [DEPTH-1:0]            valid_vec,
  output logic [DEPTH*ADDR_WIDTH-1:0] addr_flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic                  vld_q;
    logic [ADDR_WIDTH-1:0] adr_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (set_vec[g]) begin
        vld_q <= 1'b1;
      end else if (clr_vec[g]) begin
        vld_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        adr_q <= '0;
      end else if (set_vec[g]) begin
        adr_q <= set_addr;
      end
    end

    assign valid_vec[g] = vld_q;
    assign addr_flat[g*ADDR_WIDTH +: ADDR_WIDTH] = adr_q;
  end

endmodule

// File: rtl/excl_match.sv
module excl_match #(
  parameter int ID_WIDTH   = 2,
  parameter int ADDR_WIDTH = 16,
  localparam int DEPTH     = 1 << ID_WIDTH
) (
  input  logic [DEPTH-1:0]            valid_vec,
  input  logic [DEPTH*ADDR_WIDTH-1:0] addr_flat,
  input  logic [ADDR_WIDTH-1:0]       look_addr,
  input  logic [ID_WIDTH-1:0]         look_id,
  output logic [DEPTH-1:0]            addr_hit_vec,
  output logic                        own_hit
);

  logic [DEPTH-1:0] id_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign addr_hit_vec[g] = valid_vec[g] &&
                             (addr_flat[g*ADDR_WIDTH +: ADDR_WIDTH] == look_addr);
    assign id_sel[g] = (look_id == ID_WIDTH'(g));
  end

  assign own_hit = |(addr_hit_vec & id_sel);

endmodule

// File: rtl/excl_resp.sv
module excl_resp
  import excl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_valid,
  input  op_e        op,
  input  logic       own_hit,
  output logic       resp_valid,
  output logic [1:0] resp_code,
  output logic       write_permit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_code    <= RESP_OKAY;
      write_permit <= 1'b0;
    end else begin
      resp_valid <= txn_valid;
      if (txn_valid) begin
        resp_code    <= resp_for(op, own_hit);
        write_permit <= permit_for(op, own_hit);
      end else begin
        resp_code    <= RESP_OKAY;
        write_permit <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ID_WIDTH   = 2,
  parameter int ADDR_WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  txn_valid,
  input  logic [ID_WIDTH-1:0]   txn_id,
  input  logic [ADDR_WIDTH-1:0] txn_addr,
  input  logic                  txn_write,
  input  logic                  txn_excl,
  output logic                  resp_valid,
  output logic [1:0]            resp_code,
  output logic                  write_permit
);

  localparam int DEPTH = 1 << ID_WIDTH;

  op_e                        op;
  logic [DEPTH-1:0]           valid_vec;
  logic [DEPTH*ADDR_WIDTH-1:0] addr_flat;
  logic [DEPTH-1:0]           addr_hit_vec;
  logic                       own_hit;
  logic [DEPTH-1:0]           id_onehot;

  // Named internal events, observed by the checker.
  logic                       ev_reserve;
  logic                       ev_release;
  logic                       ev_excl_fail;
  logic [DEPTH-1:0]           set_vec;
  logic [DEPTH-1:0]           clr_vec;

  assign op = classify(txn_write, txn_excl);

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign id_onehot[g] = (txn_id == ID_WIDTH'(g));
  end

  assign ev_reserve   = txn_valid && (op == OP_RD_EXCL);
  assign ev_release   = txn_valid && releases(op, own_hit);
  assign ev_excl_fail = txn_valid && (op == OP_WR_EXCL) && !own_hit;
  assign set_vec      = ev_reserve ? id_onehot : '0;
  assign clr_vec      = ev_release ? addr_hit_vec : '0;

  excl_match #(
    .ID_WIDTH  (ID_WIDTH),
    .ADDR_WIDTH(ADDR_WIDTH)
  ) i_match (
    .valid_vec   (valid_vec),
    .addr_flat   (addr_flat),
    .look_addr   (txn_addr),
    .look_id     (txn_id),
    .addr_hit_vec(addr_hit_vec),
    .own_hit     (own_hit)
  );

  excl_table #(
    .ID_WIDTH  (ID_WIDTH),
    .ADDR_WIDTH(ADDR_WIDTH)
  ) i_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .set_addr (txn_addr),
    .clr_vec  (clr_vec),
    .valid_vec(valid_vec),
    .addr_flat(addr_flat)
  );

  excl_resp i_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_valid   (txn_valid),
    .op          (op),
    .own_hit     (own_hit),
    .resp_valid  (resp_valid),
    .resp_code   (resp_code),
    .write_permit(write_permit)
  );

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ID_WIDTH   = 2,
  parameter int ADDR_WIDTH = 16,
  localparam int DEPTH     = 1 << ID_WIDTH
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  txn_valid,
  input logic                  txn_write,
  input logic                  txn_excl,
  input logic                  resp_valid,
  input logic [1:0]            resp_code,
  input logic                  write_permit,
  input logic                  ev_excl_fail,
  input logic [DEPTH-1:0]      valid_vec,
  input logic [DEPTH-1:0]      set_vec,
  input logic [DEPTH-1:0]      clr_vec
);

  p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> resp_valid);

  p_no_spurious_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !resp_valid);

  p_excl_read_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_write && txn_excl) |=> (resp_code == 2'b01 && !write_permit));

  p_excl_write_consistent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_write && txn_excl) |=> (write_permit == (resp_code == 2'b01)));

  p_normal_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_write && !txn_excl) |=> (resp_code == 2'b00 && write_permit));

  p_normal_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_write && !txn_excl) |=> (resp_code == 2'b00 && !write_permit));

  p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((valid_vec & $past(clr_vec)) == '0));

  p_reserve_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((valid_vec & $past(set_vec)) == $past(set_vec)));

  p_fail_keeps_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_excl_fail |=> $stable(valid_vec));

  p_fail_no_permit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_excl_fail |=> (!write_permit && resp_code == 2'b00));

  p_single_reserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_vec) <= 1);

endmodule

bind excl_monitor excl_monitor_chk #(
  .ID_WIDTH  (ID_WIDTH),
  .ADDR_WIDTH(ADDR_WIDTH)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txn_valid   (txn_valid),
  .txn_write   (txn_write),
  .txn_excl    (txn_excl),
  .resp_valid  (resp_valid),
  .resp_code   (resp_code),
  .write_permit(write_permit),
  .ev_excl_fail(ev_excl_fail),
  .valid_vec   (valid_vec),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec)
);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int IDW        = 2;
  localparam int AW         = 16;
  localparam int NSLOT      = 1 << IDW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          txn_valid;
  logic [IDW-1:0] txn_id;
  logic [AW-1:0] txn_addr;
  logic          txn_write;
  logic          txn_excl;
  logic          resp_valid;
  logic [1:0]    resp_code;
  logic          write_permit;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Bench-side reservation model.
  bit          m_vld [NSLOT];
  logic [AW-1:0] m_adr [NSLOT];

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.ID_WIDTH(IDW), .ADDR_WIDTH(AW)) i_excl_monitor (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_id(txn_id),
    .txn_addr(txn_addr), .txn_write(txn_write), .txn_excl(txn_excl),
    .resp_valid(resp_valid), .resp_code(resp_code), .write_permit(write_permit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected outcome derived from the requirement text.
  task automatic predict(input int id, input logic [AW-1:0] a, input bit wr, input bit ex,
                         output int code, output int perm);
    bit mine;
    mine = m_vld[id] && (m_adr[id] == a);
    if (!wr && ex) begin
      code = 1; perm = 0;
      m_vld[id] = 1'b1; m_adr[id] = a;
    end else if (!wr) begin
      code = 0; perm = 0;
    end else begin
      if (ex) begin code = mine ? 1 : 0; perm = mine ? 1 : 0; end
      else begin code = 0; perm = 1; end
      if (perm == 1)
        for (int k = 0; k < NSLOT; k++)
          if (m_vld[k] && m_adr[k] == a) m_vld[k] = 1'b0;
    end
  endtask

  // One transaction: idle check, drive a cycle, sample after the capturing edge.
  task automatic txn(input string tag, input int id, input logic [AW-1:0] a,
                     input bit wr, input bit ex);
    int ec, ep;
    @(negedge clk);
    check({"R10 idle before ", tag}, resp_valid, 0);
    txn_valid = 1'b1; txn_id = IDW'(id); txn_addr = a; txn_write = wr; txn_excl = ex;
    predict(id, a, wr, ex, ec, ep);
    @(negedge clk);
    txn_valid = 1'b0;
    check({"R10 valid ", tag}, resp_valid, 1);
    check({tag, " code"}, resp_code, ec);
    check({tag, " permit"}, write_permit, ep);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [AW-1:0] pool [4];
    pool[0] = 16'h0100; pool[1] = 16'h0104; pool[2] = 16'h0200; pool[3] = 16'h0204;
    for (int k = 0; k < NSLOT; k++) begin m_vld[k] = 1'b0; m_adr[k] = '0; end
    rst_n = 1'b0; txn_valid = 1'b0; txn_id = '0; txn_addr = '0;
    txn_write = 1'b0; txn_excl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset resp_valid", resp_valid, 0);

    // R1: empty table after reset for every ID
    for (int i = 0; i < NSLOT; i++) txn("R1 excl write after reset", i, 16'h0100, 1, 1);

    // R2 + R3: reserve and win
    txn("R2 excl read", 0, 16'h0100, 0, 1);
    txn("R3 excl write match", 0, 16'h0100, 1, 1);
    // R4: two IDs share an address, winner clears both
    txn("R2 excl read id1", 1, 16'h0200, 0, 1);
    txn("R2 excl read id2", 2, 16'h0200, 0, 1);
    txn("R3 winner id2", 2, 16'h0200, 1, 1);
    txn("R4 loser id1", 1, 16'h0200, 1, 1);
    // R5: failed write leaves owner's slot
    txn("R2 excl read id3", 3, 16'h0300, 0, 1);
    txn("R5 no-slot write id0", 0, 16'h0300, 1, 1);
    txn("R5 wrong addr id3", 3, 16'h0304, 1, 1);
    txn("R5 owner still wins", 3, 16'h0300, 1, 1);
    // R6: replacement
    txn("R6 read A", 1, 16'h0400, 0, 1);
    txn("R6 read B", 1, 16'h0404, 0, 1);
    txn("R6 old addr fails", 1, 16'h0400, 1, 1);
    txn("R6 new addr wins", 1, 16'h0404, 1, 1);
    // R7: independent reservations
    txn("R7 read id0", 0, 16'h0500, 0, 1);
    txn("R7 read id1", 1, 16'h0504, 0, 1);
    txn("R7 write id1", 1, 16'h0504, 1, 1);
    txn("R7 write id0", 0, 16'h0500, 1, 1);
    // R8: normal write releases
    txn("R8 read id2", 2, 16'h0600, 0, 1);
    txn("R8 normal write", 0, 16'h0600, 1, 0);
    txn("R8 released slot fails", 2, 16'h0600, 1, 1);
    // R9: normal read keeps table
    txn("R9 read id3", 3, 16'h0700, 0, 1);
    txn("R9 normal read", 3, 16'h0704, 0, 0);
    txn("R9 normal read same addr", 0, 16'h0700, 0, 0);
    txn("R9 slot kept", 3, 16'h0700, 1, 1);

    // Seeded sweep against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      int id; bit wr, ex; string tg;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      id = int'(lfsr[1:0]);
      wr = lfsr[4];
      ex = lfsr[5] | lfsr[6];
      if (!wr && ex)      tg = "R2 sweep excl read";
      else if (!wr)       tg = "R9 sweep normal read";
      else if (!ex)       tg = "R8 sweep normal write";
      else                tg = "R3 sweep excl write";
      txn(tg, id, pool[lfsr[9:8]], wr, ex);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule